// File: doc/BRIEF.md
# SPI Register Target with CRC-8 Protection

This block is an SPI target (clock idle low, data captured on the rising SCLK edge) that gives an external controller read and write access to a small parameterised register file. Each access is one frame inside a single low period of the active-low chip select. The controller sends a direction flag, a 7-bit address and a data byte. While those bits arrive, the block shifts out a fixed header byte and then either the addressed register or zeros.

A control bit in the register file turns on CRC-8 protection. When it is on, a frame grows from 16 to 24 SCLK cycles. The controller appends a checksum of its 16 command bits. The block appends a checksum of the header byte and the data byte it returned. A write whose checksum does not match is dropped, and a sticky error flag is raised.

All SPI pins are synchronised into the system clock domain and edge-detected there. SCLK must therefore run several times slower than the system clock.

Top module: `spi_reg_target`

## Requirements
- R1: A frame is sent MSB first on SDI and sampled on rising SCLK edges. Bit 0 is the direction flag (1 = read, 0 = write). Bits 1..7 are the address, MSB first. Bits 8..15 are the write data, MSB first.
- R2: For the first 8 SCLK cycles of every frame, SDO carries the byte 0x20, MSB first. SDO changes only after falling SCLK edges.
- R3: For SDO bits 8..15, a read returns the addressed register and a write returns 0x00.
- R4: With CRC off, a write frame is committed after its 16th rising SCLK edge.
- R5: With CRC on, a frame is 24 bits. SDO bits 16..23 are the CRC of the two bytes already sent on SDO. The CRC uses polynomial x^8+x^2+x+1 (0x07), starts at 0x00 and is computed MSB first. A write commits only if SDI bits 16..23 equal the CRC of SDI bits 0..15.
- R6: With CRC on, a write whose CRC does not match leaves every register unchanged. It sets bit 0 of address 1, and that bit stays set until reset.
- R7: Bit 0 of address 0 enables CRC mode. A change takes effect from the next frame.
- R8: If chip select rises before the frame's last bit, no write is committed.
- R9: While chip select is high, sdo_oe is low and sdo is 0.
- R10: After reset, every register reads 0x00 and CRC mode is off.
- R11: Addresses at or above NUM_REGS read as 0x00 and ignore writes. Address 1 is read-only. Address 0 keeps only bit 0.
- R12: SCLK cycles beyond the frame length commit nothing further, and SDO carries 0 during them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data from controller |
| sdo | output | 1 | Serial data to controller |
| sdo_oe | output | 1 | Output enable for the SDO pad driver |

## Verification
The hardest case to reach is a write rejected by CRC. The block must be switched into CRC mode through a plain write, and then a frame must arrive whose checksum is wrong in exactly one bit. The bench first enables the mode and then sweeps write frames with correct checksums over every register. It then sends a frame with one checksum bit flipped and reads the target and the error register back in protected frames. The bench also probes frames cut short at several bit counts, and over-long frames, to confirm that nothing is committed outside the exact frame boundary.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

    localparam logic [7:0] HDR_BYTE   = 8'h20;
    localparam logic [7:0] CRC_POLY   = 8'h07;
    localparam int         ADDR_W     = 7;
    localparam int         BYTE_W     = 8;
    localparam int         CMD_BITS   = 2 * BYTE_W;
    localparam int         FRAME_CRC  = 3 * BYTE_W;
    localparam int         CNT_W      = $clog2(FRAME_CRC + 1) + 1;
    localparam int         ADDR_CTRL  = 0;
    localparam int         ADDR_ERR   = 1;

    function automatic logic [7:0] crc8_bit(input logic [7:0] crc, input logic b);
        logic fb;
        fb = crc[7] ^ b;
        return {crc[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
    endfunction

    function automatic logic [7:0] crc8_byte(input logic [7:0] crc, input logic [7:0] v);
        logic [7:0] c;
        c = crc;
        for (int i = 7; i >= 0; i--) begin
            c = crc8_bit(c, v[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic cs_start,
    output logic sdi_s
);
    localparam int PIPE = STAGES + 1;

    typedef struct packed {
        logic [PIPE-1:0] sclk_p;
        logic [PIPE-1:0] cs_p;
        logic [PIPE-1:0] sdi_p;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.sclk_p = {st_q.sclk_p[PIPE-2:0], sclk};
        st_d.cs_p   = {st_q.cs_p[PIPE-2:0], ~cs_n};
        st_d.sdi_p  = {st_q.sdi_p[PIPE-2:0], sdi};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk_rise = st_q.sclk_p[PIPE-2] & ~st_q.sclk_p[PIPE-1];
    assign sclk_fall = ~st_q.sclk_p[PIPE-2] & st_q.sclk_p[PIPE-1];
    assign cs_act    = st_q.cs_p[PIPE-2];
    assign cs_start  = st_q.cs_p[PIPE-2] & ~st_q.cs_p[PIPE-1];
    assign sdi_s     = st_q.sdi_p[PIPE-2];

endmodule

// File: rtl/spi_crc8_serial.sv
module spi_crc8_serial
    import spi_reg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       en,
    input  logic       bit_in,
    output logic [7:0] crc
);
    logic [7:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clear) begin
            crc_d = 8'h00;
        end else if (en) begin
            crc_d = crc8_bit(crc_q, bit_in);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= 8'h00;
        end else begin
            crc_q <= crc_d;
        end
    end

    assign crc = crc_q;

endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
    import spi_reg_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              set_err,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              crc_en
);
    typedef struct packed {
        logic [NUM_REGS-1:0][7:0] gen;
        logic                     crc_en;
        logic                     err;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (wr_en) begin
            if (int'(wr_addr) == ADDR_CTRL) begin
                rf_d.crc_en = wr_data[0];
            end
            for (int i = 2; i < NUM_REGS; i++) begin
                if (int'(wr_addr) == i) begin
                    rf_d.gen[i] = wr_data;
                end
            end
        end
        if (set_err) begin
            rf_d.err = 1'b1;
        end
        rf_d.gen[0] = 8'h00;
        rf_d.gen[1] = 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    always_comb begin
        rd_data = 8'h00;
        if (int'(rd_addr) == ADDR_CTRL) begin
            rd_data = {7'b0, rf_q.crc_en};
        end else if (int'(rd_addr) == ADDR_ERR) begin
            rd_data = {7'b0, rf_q.err};
        end else if (int'(rd_addr) < NUM_REGS) begin
            rd_data = rf_q.gen[rd_addr[$clog2(NUM_REGS)-1:0]];
        end
    end

    assign crc_en = rf_q.crc_en;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rf_q.err |=> rf_q.err); // R6
    AST_NO_WRITE_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        set_err |-> !wr_en); // R6
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rf_q.gen) && $stable(rf_q.crc_en)); // R8
    AST_OOR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (int'(wr_addr) >= NUM_REGS) |=> $stable(rf_q.gen) && $stable(rf_q.crc_en)); // R11

endmodule

// File: rtl/spi_reg_target.sv
module spi_reg_target
    import spi_reg_pkg::*;
#(
    parameter int NUM_REGS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdi,
    output logic sdo,
    output logic sdo_oe
);
    localparam logic [CNT_W-1:0] CNT_MAX   = '1;
    localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_CRC  = CNT_W'(FRAME_CRC - 1);
    localparam logic [CNT_W-1:0] DATA_POS  = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CRC_POS   = CNT_W'(CMD_BITS);

    logic sclk_rise, sclk_fall, cs_act, cs_start, sdi_s;
    logic [7:0] rx_crc, rd_data;
    logic crc_en, wr_en, set_err;
    logic [7:0] wr_data;

    typedef struct packed {
        logic [CNT_W-1:0]  bit_cnt;
        logic              crc_mode;
        logic              rw;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        shreg;
        logic [7:0]        data;
        logic [7:0]        out_byte;
        logic [7:0]        tx;
    } fr_t;

    fr_t fr_d, fr_q;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act),
        .cs_start(cs_start), .sdi_s(sdi_s)
    );

    spi_crc8_serial u_crc (
        .clk(clk), .rst_n(rst_n), .clear(cs_start),
        .en(cs_act && sclk_rise && (fr_q.bit_cnt < CRC_POS)),
        .bit_in(sdi_s), .crc(rx_crc)
    );

    spi_reg_file #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(fr_q.addr),
        .wr_data(wr_data), .set_err(set_err), .rd_addr(fr_q.addr),
        .rd_data(rd_data), .crc_en(crc_en)
    );

    always_comb begin
        fr_d    = fr_q;
        wr_en   = 1'b0;
        set_err = 1'b0;
        wr_data = fr_q.data;
        if (cs_start) begin
            fr_d.bit_cnt  = '0;
            fr_d.crc_mode = crc_en;
            fr_d.rw       = 1'b0;
            fr_d.addr     = '0;
            fr_d.shreg    = '0;
            fr_d.tx       = HDR_BYTE;
        end else if (cs_act && sclk_rise) begin
            fr_d.shreg = {fr_q.shreg[6:0], sdi_s};
            if (fr_q.bit_cnt != CNT_MAX) begin
                fr_d.bit_cnt = fr_q.bit_cnt + 1'b1;
            end
            if (fr_q.bit_cnt == '0) begin
                fr_d.rw = sdi_s;
            end else if (fr_q.bit_cnt <= LAST_ADDR) begin
                fr_d.addr = {fr_q.addr[ADDR_W-2:0], sdi_s};
            end
            if (fr_q.bit_cnt == LAST_DATA) begin
                fr_d.data = {fr_q.shreg[6:0], sdi_s};
                wr_data   = {fr_q.shreg[6:0], sdi_s};
                wr_en     = !fr_q.crc_mode && !fr_q.rw;
            end
            if ((fr_q.bit_cnt == LAST_CRC) && fr_q.crc_mode && !fr_q.rw) begin
                if ({fr_q.shreg[6:0], sdi_s} == rx_crc) begin
                    wr_en = 1'b1;
                end else begin
                    set_err = 1'b1;
                end
            end
        end else if (cs_act && sclk_fall) begin
            if (fr_q.bit_cnt == DATA_POS) begin
                fr_d.tx       = fr_q.rw ? rd_data : 8'h00;
                fr_d.out_byte = fr_q.rw ? rd_data : 8'h00;
            end else if (fr_q.bit_cnt == CRC_POS) begin
                fr_d.tx = fr_q.crc_mode ? crc8_byte(crc8_byte(8'h00, HDR_BYTE), fr_q.out_byte) : 8'h00;
            end else begin
                fr_d.tx = {fr_q.tx[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign sdo_oe = cs_act;
    assign sdo    = cs_act & fr_q.tx[7];

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cs_act && !cs_start |=> $stable(fr_q.crc_mode) || cs_start); // R7
    AST_CNT_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act && !cs_start |=> $stable(fr_q.bit_cnt) || cs_start); // R8
    AST_WRITE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sclk_rise && cs_act); // R4
    AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n && $stable(cs_n) && !sclk_fall && !cs_start && cs_act |=> $stable(fr_q.tx) || sclk_fall || cs_start); // R2

endmodule

// File: tb/spi_reg_target_tb.sv
module spi_reg_target_tb;
    localparam int NREG = 8;
    localparam int HALF = 8;

    logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
    logic sdo, sdo_oe;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    spi_reg_target #(.NUM_REGS(NREG)) u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    function automatic logic [7:0] tb_crc(input logic [15:0] v);
        logic [7:0] c = 8'h00;
        for (int i = 15; i >= 0; i--) begin
            logic fb = c[7] ^ v[i];
            c = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h07;
        end
        return c;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input int nbits, input logic [31:0] txw, output logic [31:0] rxw);
        rxw = '0;
        cs_n = 1'b0;
        wclk(HALF);
        for (int i = nbits - 1; i >= 0; i--) begin
            sdi = txw[i];
            wclk(HALF);
            rxw[i] = sdo;
            sclk = 1'b1;
            wclk(HALF);
            sclk = 1'b0;
        end
        wclk(HALF);
        cs_n = 1'b1;
        wclk(HALF);
    endtask

    task automatic rd(input int a, input bit crc, input string req, output logic [7:0] val);
        logic [31:0] r;
        logic [15:0] cmd = {1'b1, 7'(a), 8'h00};
        if (crc) begin
            xfer(24, {8'h0, cmd, tb_crc(cmd)}, r);
            chk(req, r[23:16], 32'h20);
            chk("R5", r[7:0], tb_crc({8'h20, r[15:8]}));
            val = r[15:8];
        end else begin
            xfer(16, {16'h0, cmd}, r);
            chk(req, r[15:8], 32'h20);
            val = r[7:0];
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d, input bit crc, input bit bad);
        logic [31:0] r;
        logic [15:0] cmd = {1'b0, 7'(a), d};
        if (crc) begin
            xfer(24, {8'h0, cmd, tb_crc(cmd) ^ {7'b0, bad}}, r);
            chk("R3", r[15:8], 32'h0);
            chk("R5", r[7:0], tb_crc(16'h2000));
        end else begin
            xfer(16, {16'h0, cmd}, r);
            chk("R2", r[15:8], 32'h20);
            chk("R3", r[7:0], 32'h0);
        end
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] shadow [NREG];
        logic [31:0] r;
        wclk(4);
        chk("R9", {sdo_oe, sdo}, 0);
        rst_n = 1'b1;
        wclk(4);
        // R10: reset values
        for (int a = 0; a < NREG; a++) begin
            rd(a, 0, "R2", v);
            chk("R10", v, 0);
            shadow[a] = 8'h00;
        end
        chk("R9", {sdo_oe, sdo}, 0);
        // R1 R4: write sweep, plain mode
        for (int a = 2; a < NREG; a++) begin
            shadow[a] = 8'((a * 37 + 5) ^ 8'hA5);
            wr(a, shadow[a], 0, 0);
        end
        for (int a = 2; a < NREG; a++) begin
            rd(a, 0, "R1", v);
            chk("R4", v, shadow[a]);
        end
        // R11: out of range and read-only
        wr(100, 8'h5A, 0, 0);
        rd(100, 0, "R2", v);
        chk("R11", v, 0);
        wr(1, 8'hFF, 0, 0);
        rd(1, 0, "R2", v);
        chk("R11", v, 0);
        for (int a = 2; a < NREG; a++) begin
            rd(a, 0, "R2", v);
            chk("R11", v, shadow[a]);
        end
        // R8: truncated frames commit nothing
        for (int n = 8; n < 16; n += 3) begin
            xfer(n, {16'h0, 1'b0, 7'd3, 8'h11} >> (16 - n), r);
        end
        rd(3, 0, "R2", v);
        chk("R8", v, shadow[3]);
        // R12: overlong read frame, trailing SDO zero
        xfer(24, {8'h0, 1'b1, 7'd4, 8'h00, 8'hFF}, r);
        chk("R12", r[15:0], {shadow[4], 8'h00});
        // R7: enable CRC mode; ctrl keeps only bit 0
        wr(0, 8'hF3, 0, 0);
        rd(0, 1, "R7", v);
        chk("R7", v, 1);
        // R5: protected writes and reads
        for (int a = 2; a < NREG; a++) begin
            shadow[a] = 8'(a * 19 + 3);
            wr(a, shadow[a], 1, 0);
        end
        for (int a = 2; a < NREG; a++) begin
            rd(a, 1, "R2", v);
            chk("R5", v, shadow[a]);
        end
        rd(1, 1, "R2", v);
        chk("R6", v, 0);
        // R8 in CRC mode: cut at 16 bits
        xfer(16, {16'h0, 1'b0, 7'd5, 8'h77}, r);
        rd(5, 1, "R2", v);
        chk("R8", v, shadow[5]);
        // R6: bad checksum rejected, sticky error
        wr(6, 8'hC3, 1, 1);
        rd(6, 1, "R2", v);
        chk("R6", v, shadow[6]);
        rd(1, 1, "R2", v);
        chk("R6", v, 1);
        wr(6, 8'h3C, 1, 0);
        shadow[6] = 8'h3C;
        rd(6, 1, "R2", v);
        chk("R6", v, 8'h3C);
        rd(1, 1, "R2", v);
        chk("R6", v, 1);
        // R7: disable CRC, plain frames again
        wr(0, 8'h00, 1, 0);
        rd(6, 0, "R7", v);
        chk("R7", v, 8'h3C);
        chk("R9", {sdo_oe, sdo}, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule